// File: doc/BRIEF.md
# Programmable-Priority Interrupt Vector Resolver

This block picks, from a set of 64 interrupt source lines, the one source that should be presented as the current vector. It produces two vectors at once. One is for the fast-interrupt (FIQ) group and the other is for the normal-interrupt (IRQ) group. A per-source steering bit decides which group a pending source belongs to. Both groups are ranked from one shared map of 2-bit priority levels.

The priority map is held in four 32-bit registers, each with sixteen 2-bit fields. Software reaches them through a plain address / write-enable / read-data port. Arbitration has two steps. It first finds the most urgent level that has any pending source in the group. Within that level it then takes the pending source with the highest index. A global enable gates vector generation. Both vectors are registered, so they reflect the inputs and the priority map as they stood at the preceding clock edge.

Top module: `ivr_resolver`

## Requirements
- R1: After reset, every priority field reads 0, both valid flags are 0 and both index outputs are 0.
- R2: A write with `wr_en` high stores `wdata` into register `addr` at the clock edge. `rdata` always shows the register selected by `addr` combinationally. Register k, bits [2j+1:2j], hold the level of source 16k+j.
- R3: Level value 0 is the most urgent and 3 the least urgent. A pending source at a lower level value always beats one at a higher value.
- R4: A source is a FIQ candidate when `pend` and `steer_fast` are both 1 for it. It is an IRQ candidate when `pend` is 1 and `steer_fast` is 0.
- R5: Each group's vector names a pending candidate at the most urgent level present among that group's candidates.
- R6: Among candidates at the same level, the highest source index wins.
- R7: A group with no candidate shows valid 0 and index 0.
- R8: While `vec_en` is 0, both vectors become valid 0 and index 0 at the next edge, whatever is pending.
- R9: Vectors are registered. The value after edge t is resolved from the inputs and the priority map as they stood just before edge t. A register write at edge t therefore first affects the vector after edge t+1.
- R10: The FIQ and IRQ vectors are resolved independently in the same cycle from the one shared priority map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_en | input | 1 | Vector generation enable |
| pend | input | 64 | Pending flag per source |
| steer_fast | input | 64 | 1 routes the source to FIQ, 0 to IRQ |
| wr_en | input | 1 | Priority register write strobe |
| addr | input | 2 | Priority register select |
| wdata | input | 32 | Priority register write data |
| rdata | output | 32 | Selected priority register contents |
| fiq_valid | output | 1 | FIQ vector valid |
| fiq_idx | output | 6 | FIQ winning source index |
| irq_valid | output | 1 | IRQ vector valid |
| irq_idx | output | 6 | IRQ winning source index |

## Verification
A priority register write and a change in arbitration can land in the same cycle. The vector resolved at that edge must still use the old map, and the new map only shows up one edge later. The bench provokes this in two ways. It runs a directed step that rewrites the level of a pending source while a rival is also pending. It also issues random writes on random cycles in which `pend` and `steer_fast` change as well. At every step, a bench model computes the expected vectors from its own copy of the map as it stood before that step's write. It updates its copy only after the edge.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
   localparam int GRP_FAST = 0;
   localparam int GRP_NORM = 1;
   localparam int NUM_GRP  = 2;

   typedef enum logic [1:0] {
      LVL_TOP  = 2'd0,
      LVL_UPR  = 2'd1,
      LVL_LWR  = 2'd2,
      LVL_BOT  = 2'd3
   } ivr_level_e;
endpackage

// File: rtl/ivr_prio_regs.sv
module ivr_prio_regs #(
   parameter int NUM_REGS = 4,
   parameter int REG_W    = 32,
   parameter int ADDR_W   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [REG_W-1:0]          wdata,
   output logic [REG_W-1:0]          rdata,
   output logic [NUM_REGS*REG_W-1:0] map_flat
);
   logic [REG_W-1:0] regs [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_REGS; k++) regs[k] <= '0;
      end else if (wr_en) begin
         regs[addr] <= wdata;
      end
   end

   assign rdata = regs[addr];

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_flat
      assign map_flat[k*REG_W +: REG_W] = regs[k];
   end
endmodule

// File: rtl/ivr_pick.sv
module ivr_pick #(
   parameter int N        = 64,
   parameter int IDX_W    = 6,
   parameter bit TIE_HIGH = 1'b1
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   assign found = |vec;

   if (TIE_HIGH) begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++)
            if (vec[i]) idx = IDX_W'(i);
      end
   end else begin : g_low
      always_comb begin
         idx = '0;
         for (int i = N-1; i >= 0; i--)
            if (vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/ivr_group_arb.sv
module ivr_group_arb #(
   parameter int NUM_SRC  = 64,
   parameter int LVL_W    = 2,
   parameter int IDX_W    = 6,
   parameter bit TIE_HIGH = 1'b1
) (
   input  logic [NUM_SRC-1:0]       req,
   input  logic [NUM_SRC*LVL_W-1:0] map_flat,
   output logic                     found,
   output logic [IDX_W-1:0]         idx
);
   localparam int NUM_LVL = 1 << LVL_W;

   logic [NUM_SRC-1:0] at_lvl [NUM_LVL];
   logic [NUM_SRC-1:0] sel;

   always_comb begin
      for (int l = 0; l < NUM_LVL; l++)
         for (int s = 0; s < NUM_SRC; s++)
            at_lvl[l][s] = req[s] && (map_flat[s*LVL_W +: LVL_W] == LVL_W'(l));
   end

   // most urgent populated level: scan from least urgent, last hit stays
   always_comb begin
      sel = '0;
      for (int l = NUM_LVL-1; l >= 0; l--)
         if (|at_lvl[l]) sel = at_lvl[l];
   end

   ivr_pick #(.N(NUM_SRC), .IDX_W(IDX_W), .TIE_HIGH(TIE_HIGH)) u_pick (
      .vec   (sel),
      .found (found),
      .idx   (idx)
   );
endmodule

// File: rtl/ivr_resolver.sv
module ivr_resolver #(
   parameter int NUM_SRC  = 64,
   parameter int LVL_W    = 2,
   parameter int REG_W    = 32,
   parameter bit TIE_HIGH = 1'b1,
   localparam int FIELDS   = REG_W / LVL_W,
   localparam int NUM_REGS = NUM_SRC / FIELDS,
   localparam int ADDR_W   = $clog2(NUM_REGS),
   localparam int IDX_W    = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vec_en,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] steer_fast,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [REG_W-1:0]   wdata,
   output logic [REG_W-1:0]   rdata,
   output logic               fiq_valid,
   output logic [IDX_W-1:0]   fiq_idx,
   output logic               irq_valid,
   output logic [IDX_W-1:0]   irq_idx
);
   import ivr_pkg::*;

   if (REG_W % LVL_W != 0) begin : g_chk_field
      $error("REG_W must be a multiple of LVL_W");
   end
   if (NUM_SRC % FIELDS != 0) begin : g_chk_src
      $error("NUM_SRC must be a multiple of fields per register");
   end
   if (NUM_REGS < 2) begin : g_chk_regs
      $error("at least two priority registers are required");
   end

   logic [NUM_SRC*LVL_W-1:0] map_flat;
   logic [NUM_SRC-1:0]       grp_req   [NUM_GRP];
   logic                     grp_found [NUM_GRP];
   logic [IDX_W-1:0]         grp_idx   [NUM_GRP];
   logic                     vld_q     [NUM_GRP];
   logic [IDX_W-1:0]         idx_q     [NUM_GRP];

   ivr_prio_regs #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .map_flat (map_flat)
   );

   assign grp_req[GRP_FAST] = pend & steer_fast;
   assign grp_req[GRP_NORM] = pend & ~steer_fast;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      ivr_group_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W),
                      .TIE_HIGH(TIE_HIGH)) u_arb (
         .req      (grp_req[g]),
         .map_flat (map_flat),
         .found    (grp_found[g]),
         .idx      (grp_idx[g])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[g] <= 1'b0;
            idx_q[g] <= '0;
         end else begin
            vld_q[g] <= vec_en && grp_found[g];
            idx_q[g] <= (vec_en && grp_found[g]) ? grp_idx[g] : '0;
         end
      end
   end

   assign fiq_valid = vld_q[GRP_FAST];
   assign fiq_idx   = idx_q[GRP_FAST];
   assign irq_valid = vld_q[GRP_NORM];
   assign irq_idx   = idx_q[GRP_NORM];
endmodule

// File: rtl/ivr_resolver_chk.sv
module ivr_resolver_chk #(
   parameter int NUM_SRC = 64,
   parameter int REG_W   = 32,
   parameter int ADDR_W  = 2,
   parameter int IDX_W   = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               vec_en,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] steer_fast,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [REG_W-1:0]   wdata,
   input logic [REG_W-1:0]   rdata,
   input logic               fiq_valid,
   input logic [IDX_W-1:0]   fiq_idx,
   input logic               irq_valid,
   input logic [IDX_W-1:0]   irq_idx
);
   logic [NUM_SRC-1:0] q_pend, q_steer;
   logic               q_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_pend  <= '0;
         q_steer <= '0;
         q_en    <= 1'b0;
      end else begin
         q_pend  <= pend;
         q_steer <= steer_fast;
         q_en    <= vec_en;
      end
   end

   assert_fiq_is_candidate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_valid |-> (q_pend[fiq_idx] && q_steer[fiq_idx]));

   assert_irq_is_candidate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (q_pend[irq_idx] && !q_steer[irq_idx]));

   assert_valid_tracks_demand_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_valid == (q_en && |(q_pend & q_steer))) &&
      (irq_valid == (q_en && |(q_pend & ~q_steer))));

   assert_disabled_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_en |=> (!fiq_valid && !irq_valid && fiq_idx == '0 && irq_idx == '0));

   assert_groups_disjoint_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_valid && irq_valid) |-> (fiq_idx != irq_idx));

   assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!$stable(addr) || rdata == $past(wdata)));
endmodule

bind ivr_resolver ivr_resolver_chk #(
   .NUM_SRC (NUM_SRC),
   .REG_W   (REG_W),
   .ADDR_W  (ADDR_W),
   .IDX_W   (IDX_W)
) u_chk (.*);

// File: tb/ivr_resolver_test.sv
module ivr_resolver_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vec_en = 1'b0;
   logic [63:0] pend = '0;
   logic [63:0] steer_fast = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        fiq_valid, irq_valid;
   logic [5:0]  fiq_idx, irq_idx;

   int          n_chk = 0;
   int          n_fail = 0;
   logic [31:0] mregs [4];

   always #5 clk = ~clk;

   ivr_resolver uut (
      .clk(clk), .rst_n(rst_n), .vec_en(vec_en), .pend(pend),
      .steer_fast(steer_fast), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .fiq_valid(fiq_valid), .fiq_idx(fiq_idx),
      .irq_valid(irq_valid), .irq_idx(irq_idx)
   );

   function automatic logic [1:0] lvl_of(int s);
      return mregs[s/16][(s%16)*2 +: 2];
   endfunction

   // returns {valid, idx}
   function automatic logic [6:0] resolve(logic [63:0] cand, logic en);
      if (!en) return '0;
      for (int l = 0; l < 4; l++)
         for (int s = 63; s >= 0; s--)
            if (cand[s] && lvl_of(s) == 2'(l)) return {1'b1, 6'(s)};
      return '0;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(string tag, logic en, logic [63:0] p, logic [63:0] st,
                       logic wr, logic [1:0] a, logic [31:0] d);
      logic [6:0] ef, ei;
      @(negedge clk);
      vec_en = en; pend = p; steer_fast = st; wr_en = wr; addr = a; wdata = d;
      ef = resolve(p & st, en);
      ei = resolve(p & ~st, en);
      @(posedge clk);
      if (wr) mregs[a] = d;
      @(negedge clk);
      wr_en = 1'b0;
      chk({tag, " fiq"}, {25'd0, fiq_valid, fiq_idx}, {25'd0, ef});
      chk({tag, " irq"}, {25'd0, irq_valid, irq_idx}, {25'd0, ei});
      chk("R2 readback", rdata, mregs[a]);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      seed = 32'h1d5a_7c03;
      void'($urandom(seed));
      for (int k = 0; k < 4; k++) mregs[k] = '0;
      // R1: reset state
      repeat (2) @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         addr = 2'(k);
         #1 chk("R1 field reset", rdata, 32'd0);
      end
      chk("R1 valid reset", {30'd0, fiq_valid, irq_valid}, 32'd0);
      chk("R1 idx reset", {20'd0, fiq_idx, irq_idx}, 32'd0);
      rst_n = 1'b1;

      // R2: write every register and read back
      for (int k = 0; k < 4; k++)
         step("R2 write", 1'b0, '0, '0, 1'b1, 2'(k), 32'hA5C3_0000 | 32'(k));
      for (int k = 0; k < 4; k++)
         step("R2 clear", 1'b0, '0, '0, 1'b1, 2'(k), 32'd0);

      // R6: tie at level 0, highest index wins in each group
      step("R6 tie", 1'b1, 64'h0000_0100_0000_0020 | 64'h3, 64'h0000_0100_0000_0020, 1'b0, 2'd0, 32'd0);
      // R3/R5: source 63 demoted to level 3, source 2 at level 1
      step("R3 set", 1'b1, '0, '0, 1'b1, 2'd3, 32'hC000_0000);
      step("R3 set", 1'b1, '0, '0, 1'b1, 2'd0, 32'h0000_0010);
      step("R5 urgency", 1'b1, 64'h8000_0000_0000_0004, '0, 1'b0, 2'd0, 32'd0);
      // R7: one group empty
      step("R7 empty", 1'b1, 64'h8000_0000_0000_0000, '0, 1'b0, 2'd0, 32'd0);
      // R8: disabled while pending
      step("R8 disabled", 1'b0, '1, 64'h5555_5555_5555_5555, 1'b0, 2'd0, 32'd0);
      // R9: write in the same cycle as arbitration uses the old map
      step("R9 same cycle", 1'b1, 64'h8000_0000_0000_0004, '0, 1'b1, 2'd3, 32'd0);
      step("R9 next cycle", 1'b1, 64'h8000_0000_0000_0004, '0, 1'b0, 2'd3, 32'd0);

      // R10 and general: random traffic with random writes
      for (int i = 0; i < 3000; i++) begin
         logic [63:0] p, st;
         p  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         st = {$urandom, $urandom};
         step("R10 random", ($urandom % 8) != 0, p, st, ($urandom % 4) == 0,
              2'($urandom), $urandom);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule